// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Shift Engine

This block moves up to eight bits at a time between a host and a serial EEPROM. The EEPROM sits on three wires: a shared bidirectional data line, a serial clock and a chip-select. The host first loads an 8-bit data register. It then writes an 8-bit command word. That write starts a command of zero to eight serial clocks. A command either shifts the data register out, most significant bit first, or samples the EEPROM's reply into the low end of the same register.

Each command carries its own settings: a bit count, a direction, a flag that releases the data-line driver once the last clock has risen, and a wait flag. When the wait flag is set, the end of the command is held back until the EEPROM raises the data line to show it is ready. A busy flag covers the whole command. A one-cycle interrupt marks the moment busy drops. The host drives chip-select directly through a register bit of its own, so multi-byte transactions are framed by host firmware.

The serial clock half-period is `SYS_HZ / (2 * SCK_HZ)` system clocks. The default values give 500 kHz from a 250 MHz system clock.

Top module: `eew_shifter`

## Requirements
- R1: After reset, busy, irq, sclk_o, sd_oe and cs_o are 0, and data_q and status are 8'h00.
- R2: A write on wr_ctrl_en while idle starts a command. From the next cycle busy is 1 and status is {busy, wfr, hiz, rd, cnt[3:0]}, where the command word bit 6 is wfr, bit 5 is hiz, bit 4 is rd, and bits 3:0 are cnt.
- R3: A command issues min(cnt, 8) serial clocks. sclk_o idles low, and each low and high half lasts DIV_HALF system clocks. Without waiting, busy stays high for (2n+1)·DIV_HALF cycles, where n is the number of clocks.
- R4: With rd=0, bits leave from data_q[7] MSB first. sd_o changes only while sclk_o is low, sd_oe is 1 at every rising edge, and data_q ends shifted left by n with zero fill.
- R5: With rd=1, sd_oe is 0 during the clocks, sd_i is sampled at each rise of sclk_o, and data_q ends as (old << n) | received bits, right-justified.
- R6: With hiz=1 and n>0, sd_oe drops one system clock after the last rise of sclk_o. With hiz=0, a write leaves sd_oe at 1 and a read leaves it at 0.
- R7: With cnt=0, no clocks are issued and sd_oe becomes the inverse of hiz.
- R8: With wfr=1 and hiz=1, busy stays high after the clocks until sd_i rises. With hiz=0, wfr has no effect.
- R9: irq is a single-cycle pulse in the first cycle that busy is low after a command.
- R10: Writes on wr_ctrl_en or wr_data_en while busy are ignored.
- R11: cs_o takes wr_val[0] on each wr_cs_en write and holds it otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_val | input | 8 | Host write value |
| wr_data_en | input | 1 | Write wr_val into the data register |
| wr_ctrl_en | input | 1 | Write wr_val as a command word and start it |
| wr_cs_en | input | 1 | Write wr_val[0] into chip-select |
| data_q | output | 8 | Data register contents |
| status | output | 8 | {busy, wfr, hiz, rd, cnt} |
| busy | output | 1 | Command in progress |
| irq | output | 1 | One-cycle pulse when busy falls |
| cs_o | output | 1 | Chip-select to the EEPROM |
| sclk_o | output | 1 | Serial clock |
| sd_o | output | 1 | Data line output value |
| sd_oe | output | 1 | Data line driver enable |
| sd_i | input | 1 | Data line input value |

## Verification
The bench tries the shifter with several kinds of command:
- Full and partial writes show whether the bit order and the zero-fill shift are right.
- Reads with distinct patterns of 8 and 3 bits show whether the received bits are right-justified over the old contents.
- An over-range count of 15 shows whether it is clamped to 8.
- Zero-count commands with each hiz value show whether the driver follows hiz alone.
- A wait command shows whether busy is held until a late ready edge. Setting wfr with hiz=0 shows whether wfr is then ignored.

Writes made while busy, and a reset in the middle of a command, check that the command and register state are not disturbed.

// File: rtl/eew_pkg.sv
package eew_pkg;
  localparam int unsigned EEW_DW = 8;
  localparam int unsigned EEW_CW = 4;
  localparam logic [EEW_CW-1:0] EEW_MAXBITS = 4'd8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2,
    ST_WAIT = 2'd3
  } eew_state_e;

  typedef struct packed {
    logic              wfr;
    logic              hiz;
    logic              rd;
    logic [EEW_CW-1:0] cnt;
  } eew_cmd_t;
endpackage

// File: rtl/eew_clkdiv.sv
module eew_clkdiv #(
  parameter int unsigned DIV_HALF = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

  logic [CW-1:0] cnt_q, cnt_n;

  assign tick = run && (cnt_q == LAST);

  always_comb begin
    cnt_n = cnt_q;
    if (!run || tick) cnt_n = '0;
    else              cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  // half period bound
  a_r3_div_bound: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));
endmodule

// File: rtl/eew_shreg.sv
module eew_shreg #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic [DW-1:0] load_val,
  input  logic          shl_en,
  input  logic          shl_bit,
  output logic [DW-1:0] q
);
  logic [DW-1:0] q_n;

  always_comb begin
    q_n = q;
    if (load_en)     q_n = load_val;
    else if (shl_en) q_n = {q[DW-2:0], shl_bit};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_n;
  end

  // host loads only while idle, shifts only while clocking
  a_r10_no_load_during_shift: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_en && shl_en));
endmodule

// File: rtl/eew_seq.sv
module eew_seq
  import eew_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  eew_cmd_t cmd_in,
  input  logic     tick,
  input  logic     sd_i,
  output logic     busy,
  output logic     run,
  output logic     rise_ev,
  output logic     fall_ev,
  output logic     sclk,
  output logic     oe,
  output logic     irq,
  output eew_cmd_t cmd_q
);
  eew_state_e        state_q, state_n;
  logic [EEW_CW-1:0] bits_q, bits_n, eff_cnt;
  logic              sclk_n, oe_n, irq_n, rise_q, sd_prev_q;
  eew_cmd_t          cmd_n;

  assign eff_cnt = (cmd_in.cnt > EEW_MAXBITS) ? EEW_MAXBITS : cmd_in.cnt;
  assign busy    = (state_q != ST_IDLE);
  assign run     = (state_q == ST_LOW) || (state_q == ST_HIGH);

  always_comb begin
    state_n = state_q;
    bits_n  = bits_q;
    sclk_n  = sclk;
    oe_n    = oe;
    cmd_n   = cmd_q;
    rise_ev = 1'b0;
    fall_ev = 1'b0;
    case (state_q)
      ST_IDLE: if (start) begin
        cmd_n   = cmd_in;
        bits_n  = eff_cnt;
        state_n = ST_LOW;
        oe_n    = (eff_cnt == '0) ? ~cmd_in.hiz : ~cmd_in.rd;
      end
      ST_LOW: if (tick) begin
        if (bits_q == '0) begin
          state_n = (cmd_q.wfr && cmd_q.hiz) ? ST_WAIT : ST_IDLE;
        end else begin
          sclk_n  = 1'b1;
          rise_ev = 1'b1;
          state_n = ST_HIGH;
        end
      end
      ST_HIGH: begin
        if (rise_q && (bits_q == 4'd1) && cmd_q.hiz) oe_n = 1'b0;
        if (tick) begin
          sclk_n  = 1'b0;
          fall_ev = 1'b1;
          bits_n  = bits_q - 4'd1;
          state_n = ST_LOW;
        end
      end
      ST_WAIT: if (sd_i && !sd_prev_q) state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
    irq_n = (state_q != ST_IDLE) && (state_n == ST_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      bits_q    <= '0;
      sclk      <= 1'b0;
      oe        <= 1'b0;
      cmd_q     <= '0;
      irq       <= 1'b0;
      rise_q    <= 1'b0;
      sd_prev_q <= 1'b1;
    end else begin
      state_q   <= state_n;
      bits_q    <= bits_n;
      sclk      <= sclk_n;
      oe        <= oe_n;
      cmd_q     <= cmd_n;
      irq       <= irq_n;
      rise_q    <= rise_ev;
      sd_prev_q <= sd_i;
    end
  end

  a_r3_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);
  a_r3_bits_bound: assert property (@(posedge clk) disable iff (!rst_n)
    bits_q <= EEW_MAXBITS);
  a_r5_read_released: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HIGH) && cmd_q.rd |-> !oe);
  a_r8_wait_needs_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT) |-> (cmd_q.wfr && cmd_q.hiz));
  a_r9_irq_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (!busy && $past(busy)));
  a_r10_cmd_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cmd_q));
endmodule

// File: rtl/eew_shifter.sv
module eew_shifter
  import eew_pkg::*;
#(
  parameter int unsigned SYS_HZ = 250_000_000,
  parameter int unsigned SCK_HZ = 500_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EEW_DW-1:0] wr_val,
  input  logic              wr_data_en,
  input  logic              wr_ctrl_en,
  input  logic              wr_cs_en,
  output logic [EEW_DW-1:0] data_q,
  output logic [EEW_DW-1:0] status,
  output logic              busy,
  output logic              irq,
  output logic              cs_o,
  output logic              sclk_o,
  output logic              sd_o,
  output logic              sd_oe,
  input  logic              sd_i
);
  localparam int unsigned DIV_RAW  = SYS_HZ / (2 * SCK_HZ);
  localparam int unsigned DIV_HALF = (DIV_RAW < 1) ? 1 : DIV_RAW;

  logic [1:0] rsync_q;
  logic       rst_sn;
  logic       cs_n, start, load_en, tick, run, rise_ev, fall_ev, shl_en, shl_bit;
  eew_cmd_t   cmd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sn = rsync_q[1];

  assign cs_n = wr_cs_en ? wr_val[0] : cs_o;
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) cs_o <= 1'b0;
    else         cs_o <= cs_n;
  end

  assign start   = wr_ctrl_en && !busy;
  assign load_en = wr_data_en && !busy;
  assign shl_en  = (rise_ev && cmd_q.rd) || (fall_ev && !cmd_q.rd);
  assign shl_bit = cmd_q.rd ? sd_i : 1'b0;

  eew_clkdiv #(.DIV_HALF(DIV_HALF)) u_div (
    .clk(clk), .rst_n(rst_sn), .run(run), .tick(tick)
  );

  eew_seq u_seq (
    .clk(clk), .rst_n(rst_sn), .start(start),
    .cmd_in(eew_cmd_t'(wr_val[EEW_DW-2:0])), .tick(tick), .sd_i(sd_i),
    .busy(busy), .run(run), .rise_ev(rise_ev), .fall_ev(fall_ev),
    .sclk(sclk_o), .oe(sd_oe), .irq(irq), .cmd_q(cmd_q)
  );

  eew_shreg #(.DW(EEW_DW)) u_sr (
    .clk(clk), .rst_n(rst_sn), .load_en(load_en), .load_val(wr_val),
    .shl_en(shl_en), .shl_bit(shl_bit), .q(data_q)
  );

  assign sd_o   = data_q[EEW_DW-1];
  assign status = {busy, cmd_q};

  // write data only moves while the clock is low
  a_r4_data_stable_high: assert property (@(posedge clk) disable iff (!rst_sn)
    (sclk_o && $past(sclk_o)) |-> $stable(sd_o));
  a_r11_cs_hold: assert property (@(posedge clk) disable iff (!rst_sn)
    !$past(wr_cs_en) |-> $stable(cs_o));
endmodule

// File: tb/eew_shifter_bench.sv
module eew_shifter_bench;
  localparam int D = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] wr_val = 8'h00;
  logic       wr_data_en = 1'b0, wr_ctrl_en = 1'b0, wr_cs_en = 1'b0;
  logic       sd_i = 1'b0;
  logic [7:0] data_q, status;
  logic       busy, irq, cs_o, sclk_o, sd_o, sd_oe;
  int         n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  eew_shifter #(.SYS_HZ(6), .SCK_HZ(1)) u_eew_shifter (
    .clk(clk), .rst_n(rst_n), .wr_val(wr_val), .wr_data_en(wr_data_en),
    .wr_ctrl_en(wr_ctrl_en), .wr_cs_en(wr_cs_en), .data_q(data_q),
    .status(status), .busy(busy), .irq(irq), .cs_o(cs_o), .sclk_o(sclk_o),
    .sd_o(sd_o), .sd_oe(sd_oe), .sd_i(sd_i)
  );

  // {pad, exp_oe, exp_n, data, ctrl, read pattern}
  localparam logic [31:0] VEC [8] = '{
    {3'b0, 1'b1, 4'd8, 8'hA5, 8'h08, 8'h00},
    {3'b0, 1'b0, 4'd4, 8'h3C, 8'h24, 8'h00},
    {3'b0, 1'b0, 4'd8, 8'h81, 8'h18, 8'h6B},
    {3'b0, 1'b0, 4'd3, 8'hF0, 8'h13, 8'hA0},
    {3'b0, 1'b1, 4'd8, 8'h55, 8'h0F, 8'h00},
    {3'b0, 1'b1, 4'd0, 8'h00, 8'h00, 8'h00},
    {3'b0, 1'b0, 4'd0, 8'hC3, 8'h20, 8'h00},
    {3'b0, 1'b1, 4'd1, 8'h80, 8'h41, 8'h00}
  };

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v, input int sel);
    @(negedge clk);
    wr_val = v;
    wr_data_en = (sel == 0);
    wr_ctrl_en = (sel == 1);
    wr_cs_en   = (sel == 2);
    @(negedge clk);
    wr_data_en = 1'b0; wr_ctrl_en = 1'b0; wr_cs_en = 1'b0;
  endtask

  task automatic check_reset_state();
    chk(busy == 0 && irq == 0 && sclk_o == 0, "R1 ctl", {busy, irq, sclk_o}, 0);
    chk(sd_oe == 0 && cs_o == 0, "R1 oe/cs", {sd_oe, cs_o}, 0);
    chk(data_q == 8'h00 && status == 8'h00, "R1 regs", {data_q, status}, 0);
  endtask

  task automatic run_cmd(input logic [7:0] d, input logic [7:0] c, input logic [7:0] rp,
                         input logic [3:0] exp_n, input logic exp_oe, input int wdel);
    int rises, cyc, base;
    logic prev, pend, oe_last, rd;
    logic [7:0] cap, mask, exp_bits, exp_d;
    rd = c[4];
    base = (2 * exp_n + 1) * D + wdel;
    wr(d, 0);
    sd_i = rp[7];
    wr(c, 1);
    chk(busy == 1, "R2 busy", busy, 1);
    chk(status == {1'b1, c[6:0]}, "R2 status", status, {1'b1, c[6:0]});
    cyc = 1; rises = 0; prev = sclk_o; pend = 0; oe_last = sd_oe; cap = 0;
    while (1) begin
      @(negedge clk);
      if (pend) begin oe_last = sd_oe; pend = 0; end
      if (sclk_o && !prev) begin
        rises++;
        cap = {cap[6:0], sd_o};
        pend = 1;
        if (rd) chk(sd_oe == 0, "R5 driver off", sd_oe, 0);
        else    chk(sd_oe == 1, "R4 driver on", sd_oe, 1);
      end
      if (!sclk_o && prev && rises < 8) sd_i = rp[3'(7 - rises)];
      prev = sclk_o;
      if (!busy) begin
        chk(irq == 1, "R9 irq pulse", irq, 1);
        break;
      end
      cyc++;
      if (wdel > 0 && cyc == base) sd_i = 1'b1;
    end
    @(negedge clk);
    chk(irq == 0, "R9 irq one cycle", irq, 0);
    sd_i = 1'b0;
    chk(rises == int'(exp_n), "R3 clock count", rises, exp_n);
    chk(cyc == base, "R3/R8 busy length", cyc, base);
    mask = 8'((16'h1 << exp_n) - 16'h1);
    exp_bits = 8'({8'h00, d} >> (8 - exp_n));
    if (!rd && exp_n > 0) chk((cap & mask) == exp_bits, "R4 bits MSB first", cap & mask, exp_bits);
    if (exp_n > 0) chk(oe_last == exp_oe, "R6 release after last rise", oe_last, exp_oe);
    chk(sd_oe == exp_oe, "R6/R7 final driver", sd_oe, exp_oe);
    exp_d = 8'({8'h00, d} << exp_n) | (rd ? 8'({rp, 8'h00} >> (16 - exp_n)) : 8'h00);
    if (exp_n == 0) exp_d = d;
    chk(data_q == exp_d, rd ? "R5 read data" : "R4 shifted data", data_q, exp_d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R3 act=timeout exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_reset_state();

    for (int i = 0; i < 8; i++) begin
      run_cmd(VEC[i][23:16], VEC[i][15:8], VEC[i][7:0], VEC[i][27:24], VEC[i][28], 0);
    end

    // R8: wait for ready with a late rising edge
    run_cmd(8'h80, 8'h62, 8'h00, 4'd2, 1'b0, 10);

    // R10: writes while busy are ignored
    wr(8'hA5, 0);
    wr(8'h04, 1);
    wr(8'h18, 1);
    wr(8'hFF, 0);
    chk(status[6:0] == 7'h04, "R10 ctrl ignored", status[6:0], 7'h04);
    while (busy) @(negedge clk);
    chk(data_q == 8'h50, "R10 data ignored", data_q, 8'h50);

    // R11: chip-select follows host bit
    wr(8'h01, 2);
    chk(cs_o == 1, "R11 cs high", cs_o, 1);
    wr(8'hFE, 0);
    chk(cs_o == 1, "R11 cs held", cs_o, 1);
    wr(8'hFE, 2);
    chk(cs_o == 0, "R11 cs low", cs_o, 0);

    // R1: reset in the middle of a command
    wr(8'h01, 2);
    wr(8'hC3, 0);
    wr(8'h08, 1);
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check_reset_state();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_reset_state();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule